// File: doc/BRIEF.md
# Boot-Region Program/Erase Permission Guard

This block sits between a command decoder and the program/erase sequencer of a flash array. It maps each 19-bit word address onto one of eleven independently erasable regions. These are one boot region, two parameter regions, one 96 KB region and seven 128 KB regions. A parameter places the boot region either at the bottom or at the top of the address space. For each write or erase request, the block decides at once whether the operation may start. While the operation runs, an internal cycle counter stands in for the array's busy time, and the block keeps checking the protection inputs for that whole period.

Operations on the boot region need a protection release: either the high-voltage unlock flag or the write-protect pin held high, together with a good programming supply. The release must stay valid until the operation completes, and if it lapses the operation is aborted. Every other region accepts operations without any release. Failures are recorded in sticky error bits of a small status word. These bits clear on a status-clear strobe or on power-down, and power-down also cancels any operation in progress.

Top module: `bg_guard`

## Requirements
- R1: With the boot region at the bottom, word addresses below 02000h give region index 0 (boot). Addresses 02000h–02FFFh give index 1, 03000h–03FFFh give index 2, and 04000h–0FFFFh give index 3. Any higher address gives index 3 plus address bits [18:16].
- R2: With the boot region at the top, the index is the one R1 gives for the bitwise inverse of the address, so 7E000h–7FFFFh is index 0.
- R3: An idle request to index 0 is accepted only if (unlock flag OR write-protect pin) AND supply-good. Otherwise, in the cycle after sampling, the block gives no grant, stays idle, and sets the write or erase error bit matching the request type, plus the supply error bit if supply-good was low.
- R4: An idle request to any index other than 0 is accepted whatever the unlock, write-protect and supply inputs are, and changes in those inputs during the operation have no effect.
- R5: An accepted request gives a one-cycle grant pulse in the cycle after sampling. The block then stays busy for WR_CYCLES (write) or ERA_CYCLES (erase) cycles, and gives a one-cycle done pulse as busy falls.
- R6: While a boot-region operation is busy, if (unlock OR write-protect) AND supply-good goes false, the next cycle shows a one-cycle abort pulse, busy low and no done. The write or erase error bit matching the operation is set, plus the supply error bit if supply-good was low. An abort in the final busy cycle wins over completion.
- R7: Power-down clears all error bits and any busy operation in the next cycle, and requests are ignored while it is asserted.
- R8: A request presented while busy has no effect on status, grant or the running operation's completion time.
- R9: Error bits hold until a status-clear strobe or power-down. If a clear and a new error fall in the same cycle, the new error bit ends up set.
- R10: Status bit 0 is ready (high exactly when not busy), bit 1 is the supply error, bit 2 the write error, and bit 3 the erase error; after reset the status is 0001b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_i | input | 1 | Power-down, synchronous, active high |
| clr_status_i | input | 1 | Clear sticky error bits |
| req_valid_i | input | 1 | Operation request strobe |
| req_erase_i | input | 1 | 1 = erase, 0 = write |
| req_addr_i | input | ADDR_W | Word address of the request |
| unlock_hv_i | input | 1 | High-voltage unlock present |
| wp_i | input | 1 | Write-protect pin level (high releases boot region) |
| vpp_ok_i | input | 1 | Programming supply within range |
| blk_idx_o | output | 4 | Region index of req_addr_i |
| grant_o | output | 1 | One-cycle accept pulse |
| abort_o | output | 1 | One-cycle abort pulse |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Operation in progress |
| status_o | output | 4 | Ready and sticky error bits |

## Verification
An abort and a normal completion can both apply on the same clock edge, in the final busy cycle of a boot-region operation. The bench drops the unlock flag exactly one cycle before the expected done pulse. It then checks that the following cycle shows the abort and the write error but no done pulse, and that no late done ever appears. A second collision pairs a status-clear strobe with a fresh rejection on the same edge, and the bench expects the new error bit to survive.

// File: rtl/bg_pkg.sv
package bg_pkg;
   localparam int STAT_W   = 4;
   localparam int IDX_W    = 4;
   localparam int MAP_AW   = 19;
   localparam int ST_READY = 0;
   localparam int ST_VPP   = 1;
   localparam int ST_WRITE = 2;
   localparam int ST_ERASE = 3;

   typedef enum logic [1:0] {
      BG_IDLE = 2'd0,
      BG_BUSY = 2'd1
   } bg_state_e;

   typedef struct packed {
      logic erase_err;
      logic write_err;
      logic vpp_err;
   } bg_err_t;
endpackage

// File: rtl/bg_region_decode.sv
module bg_region_decode #(
   parameter int ADDR_W   = 19,
   parameter bit TOP_BOOT = 1'b0
) (
   input  logic [ADDR_W-1:0]        addr_i,
   output logic [bg_pkg::IDX_W-1:0] idx_o,
   output logic                     is_boot_o
);
   localparam logic [ADDR_W-1:0] PAR0_BASE = ADDR_W'('h02000);
   localparam logic [ADDR_W-1:0] PAR1_BASE = ADDR_W'('h03000);
   localparam logic [ADDR_W-1:0] MID_BASE  = ADDR_W'('h04000);
   localparam logic [ADDR_W-1:0] BIG_BASE  = ADDR_W'('h10000);
   localparam int               BIG_LSB   = 16;

   if (ADDR_W != bg_pkg::MAP_AW) begin : g_bad_width
      $error("bg_region_decode: ADDR_W must be %0d", bg_pkg::MAP_AW);
   end

   logic [ADDR_W-1:0] eff;

   if (TOP_BOOT) begin : g_top
      assign eff = ~addr_i;
   end else begin : g_bottom
      assign eff = addr_i;
   end

   always_comb begin
      if (eff < PAR0_BASE)      idx_o = 4'd0;
      else if (eff < PAR1_BASE) idx_o = 4'd1;
      else if (eff < MID_BASE)  idx_o = 4'd2;
      else if (eff < BIG_BASE)  idx_o = 4'd3;
      else                      idx_o = 4'd3 + {1'b0, eff[ADDR_W-1:BIG_LSB]};
   end

   assign is_boot_o = (idx_o == '0);
endmodule

// File: rtl/bg_op_timer.sv
module bg_op_timer #(
   parameter int WR_CYCLES  = 6,
   parameter int ERA_CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic load_i,
   input  logic load_erase_i,
   output logic expired_o
);
   localparam int MAX_C = (WR_CYCLES > ERA_CYCLES) ? WR_CYCLES : ERA_CYCLES;
   localparam int CNT_W = $clog2(MAX_C + 1);
   localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYCLES - 1);
   localparam logic [CNT_W-1:0] ER_LOAD = CNT_W'(ERA_CYCLES - 1);

   if (WR_CYCLES < 1 || ERA_CYCLES < 1) begin : g_bad_len
      $error("bg_op_timer: cycle counts must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (clear_i)         cnt_q <= '0;
      else if (load_i)          cnt_q <= load_erase_i ? ER_LOAD : WR_LOAD;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/bg_err_status.sv
module bg_err_status (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear_i,
   input  bg_pkg::bg_err_t set_i,
   output bg_pkg::bg_err_t err_o
);
   bg_pkg::bg_err_t err_q;
   bg_pkg::bg_err_t err_d;

   always_comb begin
      err_d = clear_i ? '0 : err_q;
      err_d = err_d | set_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= '0;
      else        err_q <= err_d;
   end

   assign err_o = err_q;
endmodule

// File: rtl/bg_guard.sv
module bg_guard #(
   parameter int ADDR_W     = 19,
   parameter bit TOP_BOOT   = 1'b0,
   parameter int WR_CYCLES  = 6,
   parameter int ERA_CYCLES = 40
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      pd_i,
   input  logic                      clr_status_i,
   input  logic                      req_valid_i,
   input  logic                      req_erase_i,
   input  logic [ADDR_W-1:0]         req_addr_i,
   input  logic                      unlock_hv_i,
   input  logic                      wp_i,
   input  logic                      vpp_ok_i,
   output logic [bg_pkg::IDX_W-1:0]  blk_idx_o,
   output logic                      grant_o,
   output logic                      abort_o,
   output logic                      done_o,
   output logic                      busy_o,
   output logic [bg_pkg::STAT_W-1:0] status_o
);
   import bg_pkg::*;

   logic      dec_boot;
   logic      tmr_exp;
   bg_state_e state_q;
   logic      op_boot_q;
   logic      op_erase_q;
   logic      grant_q, abort_q, done_q;
   bg_err_t   err_set, err_now;

   bg_region_decode #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) u_dec (
      .addr_i    (req_addr_i),
      .idx_o     (blk_idx_o),
      .is_boot_o (dec_boot)
   );

   logic busy;
   logic boot_ok;
   logic take, allow, accept, reject;
   logic guard_lost, finish;

   assign busy       = (state_q == BG_BUSY);
   assign boot_ok    = (unlock_hv_i | wp_i) & vpp_ok_i;
   assign take       = req_valid_i & ~busy & ~pd_i;
   assign allow      = ~dec_boot | boot_ok;
   assign accept     = take & allow;
   assign reject     = take & ~allow;
   assign guard_lost = busy & op_boot_q & ~boot_ok & ~pd_i;
   assign finish     = busy & tmr_exp & ~guard_lost & ~pd_i;

   bg_op_timer #(.WR_CYCLES(WR_CYCLES), .ERA_CYCLES(ERA_CYCLES)) u_tmr (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear_i      (pd_i),
      .load_i       (accept),
      .load_erase_i (req_erase_i),
      .expired_o    (tmr_exp)
   );

   always_comb begin
      err_set.write_err = (reject & ~req_erase_i) | (guard_lost & ~op_erase_q);
      err_set.erase_err = (reject &  req_erase_i) | (guard_lost &  op_erase_q);
      err_set.vpp_err   = (reject | guard_lost) & ~vpp_ok_i;
   end

   bg_err_status u_err (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (pd_i | clr_status_i),
      .set_i   (err_set),
      .err_o   (err_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= BG_IDLE;
         op_boot_q  <= 1'b0;
         op_erase_q <= 1'b0;
         grant_q    <= 1'b0;
         abort_q    <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         grant_q <= accept;
         abort_q <= guard_lost;
         done_q  <= finish;
         if (pd_i) begin
            state_q <= BG_IDLE;
         end else if (accept) begin
            state_q    <= BG_BUSY;
            op_boot_q  <= dec_boot;
            op_erase_q <= req_erase_i;
         end else if (guard_lost || finish) begin
            state_q <= BG_IDLE;
         end
      end
   end

   assign grant_o  = grant_q;
   assign abort_o  = abort_q;
   assign done_o   = done_q;
   assign busy_o   = busy;

   always_comb begin
      status_o           = '0;
      status_o[ST_READY] = ~busy;
      status_o[ST_VPP]   = err_now.vpp_err;
      status_o[ST_WRITE] = err_now.write_err;
      status_o[ST_ERASE] = err_now.erase_err;
   end
endmodule

// File: rtl/bg_guard_chk.sv
module bg_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pd_i,
   input logic       clr_status_i,
   input logic       req_valid_i,
   input logic       unlock_hv_i,
   input logic       wp_i,
   input logic       vpp_ok_i,
   input logic [3:0] blk_idx_o,
   input logic       grant_o,
   input logic       abort_o,
   input logic       done_o,
   input logic       busy_o,
   input logic [3:0] status_o,
   input logic       op_boot_q
);
   logic rel_ok;
   assign rel_ok = (unlock_hv_i | wp_i) & vpp_ok_i;

   p_reject_boot_r3: assert property (@(posedge clk) disable iff (!rst_n || pd_i)
      (req_valid_i && !busy_o && blk_idx_o == 4'd0 && !rel_ok) |=> (!grant_o && !busy_o));

   p_nonboot_accept_r4: assert property (@(posedge clk) disable iff (!rst_n || pd_i)
      (req_valid_i && !busy_o && blk_idx_o != 4'd0) |=> (grant_o && busy_o));

   p_guard_abort_r6: assert property (@(posedge clk) disable iff (!rst_n || pd_i)
      (busy_o && op_boot_q && !rel_ok) |=> (abort_o && !busy_o));

   p_abort_beats_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(abort_o && done_o));

   p_pd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pd_i |=> (status_o == 4'b0001));

   p_grant_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n || pd_i)
      grant_o |-> !$past(busy_o));

   p_write_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n || pd_i)
      (status_o[2] && !clr_status_i) |=> status_o[2]);
endmodule

bind bg_guard bg_guard_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pd_i         (pd_i),
   .clr_status_i (clr_status_i),
   .req_valid_i  (req_valid_i),
   .unlock_hv_i  (unlock_hv_i),
   .wp_i         (wp_i),
   .vpp_ok_i     (vpp_ok_i),
   .blk_idx_o    (blk_idx_o),
   .grant_o      (grant_o),
   .abort_o      (abort_o),
   .done_o       (done_o),
   .busy_o       (busy_o),
   .status_o     (status_o),
   .op_boot_q    (op_boot_q)
);

// File: tb/bg_guard_bench.sv
`timescale 1ns/1ps
module bg_guard_bench;
   localparam int WRC = 3;
   localparam int ERC = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pd = 1'b0, clr = 1'b0, rv = 1'b0, rer = 1'b0;
   logic [18:0] addr = '0;
   logic hv = 1'b0, wp = 1'b0, vpp = 1'b0;

   logic [3:0] idx_b, idx_t, st, st_t;
   logic gr, ab, dn, bz, gr_t, ab_t, dn_t, bz_t;

   int n_vec = 0;
   int n_bad = 0;
   bit ended = 1'b0;

   always #2.5 clk = ~clk;

   bg_guard #(.ADDR_W(19), .TOP_BOOT(1'b0), .WR_CYCLES(WRC), .ERA_CYCLES(ERC)) u_bg_guard (
      .clk(clk), .rst_n(rst_n), .pd_i(pd), .clr_status_i(clr), .req_valid_i(rv),
      .req_erase_i(rer), .req_addr_i(addr), .unlock_hv_i(hv), .wp_i(wp), .vpp_ok_i(vpp),
      .blk_idx_o(idx_b), .grant_o(gr), .abort_o(ab), .done_o(dn), .busy_o(bz), .status_o(st));

   bg_guard #(.ADDR_W(19), .TOP_BOOT(1'b1), .WR_CYCLES(WRC), .ERA_CYCLES(ERC)) u_bg_guard_top (
      .clk(clk), .rst_n(rst_n), .pd_i(1'b0), .clr_status_i(1'b0), .req_valid_i(1'b0),
      .req_erase_i(1'b0), .req_addr_i(addr), .unlock_hv_i(1'b0), .wp_i(1'b0), .vpp_ok_i(1'b0),
      .blk_idx_o(idx_t), .grant_o(gr_t), .abort_o(ab_t), .done_o(dn_t), .busy_o(bz_t), .status_o(st_t));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] exp_idx(input logic [18:0] a, input bit top);
      logic [18:0] e;
      e = top ? ~a : a;
      if (e < 19'h02000)      return 4'd0;
      else if (e < 19'h03000) return 4'd1;
      else if (e < 19'h04000) return 4'd2;
      else if (e < 19'h10000) return 4'd3;
      else                    return 4'd3 + {1'b0, e[18:16]};
   endfunction

   task automatic clear_status();
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   task automatic request(input logic [18:0] a, input logic er);
      addr = a; rer = er; rv = 1'b1;
      @(negedge clk);
      rv = 1'b0;
   endtask

   task automatic finish_bench();
      if (!ended) begin
         ended = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_bench();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 reset status", st, 4'b0001);
      chk("R10 reset busy", bz, 0);
      chk("R5 reset grant", gr, 0);

      // R1 / R2 decode sweep
      for (int a = 0; a < 'h80000; a += 'h200) begin
         for (int k = 0; k < 2; k++) begin
            addr = (k == 0) ? 19'(a) : 19'(a + 'h1FF);
            #0.5;
            chk("R1 bottom decode", idx_b, exp_idx(addr, 1'b0));
            chk("R2 top decode", idx_t, exp_idx(addr, 1'b1));
         end
      end
      @(negedge clk);

      // R3 / R4 / R5 permission sweep
      for (int b = 0; b < 2; b++) begin
         for (int e = 0; e < 2; e++) begin
            for (int g = 0; g < 8; g++) begin
               logic ok;
               int n;
               hv = g[0]; wp = g[1]; vpp = g[2];
               ok = (b == 0) || ((g[0] || g[1]) && g[2]);
               n = e ? ERC : WRC;
               request(b ? 19'h01000 : 19'h45000, 1'(e));
               chk(b ? "R3 grant" : "R4 grant", gr, ok);
               chk(b ? "R3 busy" : "R4 busy", bz, ok);
               if (ok) begin
                  chk("R5 status during op", st, 4'b0000);
                  for (int k = 2; k <= n; k++) begin
                     @(negedge clk);
                     chk("R5 busy length", bz, 1);
                     chk("R5 grant one cycle", gr, 0);
                  end
                  @(negedge clk);
                  chk("R5 done pulse", dn, 1);
                  chk("R5 idle after", st, 4'b0001);
                  @(negedge clk);
                  chk("R5 done one cycle", dn, 0);
               end else begin
                  chk("R3 error bits", st, {1'(e), 1'(!e), !g[2], 1'b1});
               end
               clear_status();
               chk("R9 cleared", st, 4'b0001);
            end
         end
      end

      // R6 unlock drops mid write
      hv = 1; wp = 0; vpp = 1;
      request(19'h00100, 1'b0);
      chk("R6 granted", gr, 1);
      hv = 0;
      @(negedge clk);
      chk("R6 abort pulse", ab, 1);
      chk("R6 status write err", st, 4'b0101);
      repeat (4) begin
         @(negedge clk);
         chk("R6 no late done", dn, 0);
      end
      clear_status();

      // R6 supply drops mid erase
      hv = 0; wp = 1; vpp = 1;
      request(19'h01F00, 1'b1);
      @(negedge clk);
      vpp = 0;
      @(negedge clk);
      chk("R6 abort on supply", ab, 1);
      chk("R6 erase+vpp err", st, 4'b1011);
      clear_status();

      // R6 collision: drop in final busy cycle
      hv = 1; wp = 0; vpp = 1;
      request(19'h00000, 1'b0);   // n1
      @(negedge clk);             // n2
      @(negedge clk);             // n3
      chk("R6 still busy", bz, 1);
      hv = 0;
      @(negedge clk);             // n4
      chk("R6 collision abort", ab, 1);
      chk("R6 collision no done", dn, 0);
      chk("R6 collision status", st, 4'b0101);
      @(negedge clk);
      chk("R6 collision no late done", dn, 0);
      clear_status();

      // R4 non-boot op ignores guard inputs changing
      hv = 1; wp = 1; vpp = 1;
      request(19'h7FFFF, 1'b0);
      hv = 0; wp = 0; vpp = 0;
      @(negedge clk); @(negedge clk);
      chk("R4 no abort", ab, 0);
      @(negedge clk);
      chk("R4 done on time", dn, 1);
      chk("R4 no error", st, 4'b0001);

      // R8 request while busy ignored
      request(19'h20000, 1'b1);          // n1 accepted, erase
      request(19'h00000, 1'b0);          // rejected-if-idle request while busy
      chk("R8 no grant", gr, 0);
      chk("R8 status unchanged", st, 4'b0000);
      for (int k = 3; k <= ERC; k++) @(negedge clk);
      chk("R8 still busy", bz, 1);
      @(negedge clk);
      chk("R8 done on time", dn, 1);
      chk("R8 no error", st, 4'b0001);

      // R9 sticky and clear/set collision
      request(19'h00000, 1'b0);
      repeat (5) @(negedge clk);
      chk("R9 sticky", st, 4'b0111);
      clr = 1; addr = 19'h00000; rer = 1'b1; rv = 1'b1;
      @(negedge clk);
      clr = 0; rv = 0;
      chk("R9 set wins over clear", st, 4'b1011);
      clear_status();

      // R7 power-down
      vpp = 1; hv = 0;
      request(19'h00000, 1'b1);          // reject, sets erase err
      request(19'h30000, 1'b1);          // accepted
      pd = 1; rv = 1; addr = 19'h30000;
      @(negedge clk);
      chk("R7 pd clears", st, 4'b0001);
      @(negedge clk);
      chk("R7 request ignored in pd", gr, 0);
      pd = 0; rv = 0;
      repeat (ERC + 1) begin
         @(negedge clk);
         chk("R7 no done after pd", dn, 0);
      end
      chk("R7 idle", st, 4'b0001);

      finish_bench();
   end
endmodule